// File: doc/BRIEF.md
# Request Parity Checker with Selectable Polarity

This block watches the request channel entering an on-chip interconnect from the protocol-translation wrapper that surrounds it. Every request carries an address field, a control field and one parity bit produced by the initiator. When a request is accepted, which is any cycle where both valid and ready are high, the checker computes the parity of the address and control bits and compares it with the received bit. Even or odd convention is chosen by a polarity select. A mismatch produces a one-cycle error pulse for a central error aggregator, and it also sets a sticky flag that stays high until an explicit clear.

The checker only observes the handshake. It never drives ready and never stalls the channel. Back-pressure is entirely the business of the initiator and target: a request may sit with valid high and ready low for any number of cycles, and it is checked once, in the cycle where ready finally joins valid. Checking cannot be switched off. The only test hook is the polarity select. Setting it opposite to the sender's convention makes every accepted request fail, which gives a way to inject faults on purpose.

Top module: `req_parity_checker`

## Requirements
- R1: With the polarity select low (even), an accepted request fails when the received parity bit differs from the XOR of all address and control bits.
- R2: With the polarity select high (odd), an accepted request fails when the received parity bit differs from the inverted XOR of all address and control bits.
- R3: Flipping any single bit of the address, the control field or the parity bit on an otherwise correct request makes that request fail.
- R4: Only accepted requests (valid and ready both high in the same cycle) are checked. A cycle with valid high and ready low, or with ready high and valid low, never raises the error pulse, whatever the field values are.
- R5: The error pulse is high for exactly the one cycle after the clock edge at which a failing request is accepted. Failing requests accepted on consecutive edges give consecutive high cycles, and a passing request gives a low cycle.
- R6: The sticky flag rises together with the error pulse and stays high until the clear input is sampled high. A clear sampled on the same edge as a failing acceptance leaves the flag set.
- R7: The convention applied to a request is the polarity select value sampled in the first cycle that request is valid. Changes on the select while the request waits for ready have no effect on that request.
- R8: When the select is opposite to the sender's convention, every accepted request fails.
- R9: While reset is asserted (active low, asynchronous), the error pulse and the sticky flag are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid from the initiator side |
| req_ready_i | input | 1 | Request ready from the target side |
| req_addr_i | input | ADDR_W (32) | Request address, covered by parity |
| req_ctrl_i | input | CTRL_W (8) | Request control field, covered by parity |
| req_par_i | input | 1 | Parity bit sent with the request |
| par_odd_i | input | 1 | Polarity select: 0 even, 1 odd |
| err_clr_i | input | 1 | Clears the sticky flag |
| err_pulse_o | output | 1 | One-cycle error pulse to the aggregator |
| err_sticky_o | output | 1 | Sticky error flag |

## Verification
Both outputs are registered. A request accepted at a rising edge shows its result on the error pulse and the sticky flag right after that edge, and a clear sampled at an edge takes effect right after the same edge. The bench changes inputs only on falling edges. A behavioural model is updated at each rising edge from the inputs that were stable across that edge, and both outputs are compared with the model at the next falling edge, half a period after the register update. The stall scenarios hold a request for several cycles and change the polarity and the field values mid-wait, so that each check falls in the one cycle where the handshake completes.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } par_mode_e;

  function automatic int unsigned div_up(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/rpc_xor_tree.sv
module rpc_xor_tree #(
  parameter int unsigned WIDTH = 40,
  parameter int unsigned LEAF  = 4
) (
  input  logic [WIDTH-1:0] data_i,
  output logic             par_o
);
  import rpc_pkg::*;

  localparam int unsigned NLEAF = div_up(WIDTH, LEAF);
  localparam int unsigned PADW  = NLEAF * LEAF;

  logic [PADW-1:0]  padded;
  logic [NLEAF-1:0] leaf_par;

  assign padded = PADW'(data_i);

  for (genvar g = 0; g < NLEAF; g++) begin : g_leaf
    assign leaf_par[g] = ^padded[g*LEAF +: LEAF];
  end

  assign par_o = ^leaf_par;

endmodule

// File: rtl/rpc_pol_hold.sv
module rpc_pol_hold (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 ready_i,
  input  logic                 sel_i,
  output rpc_pkg::par_mode_e   mode_o
);
  import rpc_pkg::*;

  logic      waiting_q;
  par_mode_e held_q;

  // A request still waiting from last cycle keeps the convention it arrived with
  always_comb mode_o = waiting_q ? held_q : par_mode_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waiting_q <= 1'b0;
      held_q    <= PAR_EVEN;
    end else begin
      waiting_q <= valid_i && !ready_i;
      held_q    <= mode_o;
    end
  end

  p_mode_frozen_in_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ready_i) |=> $stable(mode_o))
    else $error("polarity changed during a stalled request");

endmodule

// File: rtl/rpc_err_report.sv
module rpc_err_report (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  input  logic clr_i,
  output logic pulse_o,
  output logic sticky_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_o  <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      pulse_o <= fail_i;
      if (fail_i)     sticky_o <= 1'b1;
      else if (clr_i) sticky_o <= 1'b0;
    end
  end

  p_sticky_with_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> sticky_o)
    else $error("pulse without sticky flag");

  p_sticky_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_o && !clr_i) |=> sticky_o)
    else $error("sticky flag dropped without clear");

  p_clear_works_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !fail_i) |=> !sticky_o)
    else $error("clear did not drop the sticky flag");

  p_pulse_follows_fail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |=> pulse_o)
    else $error("failing request gave no pulse");

endmodule

// File: rtl/req_parity_checker.sv
module req_parity_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned LEAF   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_ready_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CTRL_W-1:0] req_ctrl_i,
  input  logic              req_par_i,
  input  logic              par_odd_i,
  input  logic              err_clr_i,
  output logic              err_pulse_o,
  output logic              err_sticky_o
);
  import rpc_pkg::*;

  localparam int unsigned FIELD_W = ADDR_W + CTRL_W;

  logic      accept;
  logic      field_par;
  logic      expect_par;
  logic      fail;
  par_mode_e mode;

  assign accept = req_valid_i && req_ready_i;

  rpc_xor_tree #(.WIDTH(FIELD_W), .LEAF(LEAF)) u_tree (
    .data_i ({req_addr_i, req_ctrl_i}),
    .par_o  (field_par)
  );

  rpc_pol_hold u_pol (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .ready_i (req_ready_i),
    .sel_i   (par_odd_i),
    .mode_o  (mode)
  );

  // Checking has no enable: every accepted request is evaluated
  assign expect_par = field_par ^ (mode == PAR_ODD);
  assign fail       = accept && (req_par_i != expect_par);

  rpc_err_report u_rep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fail_i   (fail),
    .clr_i    (err_clr_i),
    .pulse_o  (err_pulse_o),
    .sticky_o (err_sticky_o)
  );

  p_no_err_without_accept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> $past(req_valid_i && req_ready_i))
    else $error("error pulse without an accepted request");

endmodule

// File: tb/req_parity_checker_test.sv
`timescale 1ns/1ps
module req_parity_checker_test;

  localparam int AW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0, ready = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] ctrl = '0;
  logic          par = 1'b0, odd = 1'b0, clr = 1'b0;
  logic          err_pulse, err_sticky;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  string cur_req = "R9";

  // reference model state
  bit m_pulse = 0, m_sticky = 0, m_pending = 0, m_cap_odd = 0;

  always #2.5 clk = ~clk;

  req_parity_checker uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_i(ready),
    .req_addr_i(addr), .req_ctrl_i(ctrl), .req_par_i(par), .par_odd_i(odd),
    .err_clr_i(clr), .err_pulse_o(err_pulse), .err_sticky_o(err_sticky)
  );

  function automatic bit sender_par(input logic [AW-1:0] a, input logic [CW-1:0] c, input bit odd_mode);
    int ones = $countones(a) + $countones(c);
    // even: total ones including parity is even; odd: total is odd
    return bit'(ones % 2) ^ odd_mode;
  endfunction

  task automatic check(input string req, input bit act, input bit exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // One clock: update model at rising edge, compare at the falling edge after it
  task automatic tick();
    bit use_odd, fail_now;
    @(posedge clk);
    if (!rst_n) begin
      m_pulse = 0; m_sticky = 0; m_pending = 0; m_cap_odd = 0;
    end else begin
      use_odd = m_pending ? m_cap_odd : odd;
      fail_now = valid && ready && (par != sender_par(addr, ctrl, use_odd));
      m_pulse = fail_now;
      if (fail_now) m_sticky = 1;
      else if (clr) m_sticky = 0;
      m_pending = valid && !ready;
      m_cap_odd = use_odd;
    end
    @(negedge clk);
    check(cur_req, err_pulse, m_pulse, "err_pulse");
    check(cur_req, err_sticky, m_sticky, "err_sticky");
  endtask

  task automatic idle(input int n);
    valid = 0; ready = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  // Present a request, wait 'stall' cycles, then complete it; valid left high
  task automatic send(input logic [AW-1:0] a, input logic [CW-1:0] c, input bit p, input int stall);
    valid = 1; addr = a; ctrl = c; par = p; ready = 0;
    for (int i = 0; i < stall; i++) tick();
    ready = 1;
    tick();
  endtask

  task automatic clear_sticky();
    valid = 0; ready = 0; clr = 1; tick(); clr = 0;
  endtask

  initial begin : watchdog
    #(200000 * 5.0);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [AW-1:0] a;
    logic [CW-1:0] c;
    @(negedge clk);
    // R9: outputs low in reset
    cur_req = "R9";
    for (int i = 0; i < 3; i++) tick();
    check("R9", err_pulse, 1'b0, "reset err_pulse");
    check("R9", err_sticky, 1'b0, "reset err_sticky");
    rst_n = 1;
    idle(2);

    // R1: even convention, good then bad requests
    cur_req = "R1"; odd = 0;
    for (int i = 0; i < 30; i++) begin
      a = $urandom; c = 8'($urandom);
      send(a, c, sender_par(a, c, 0), i % 3);
      check("R1", err_pulse, 1'b0, "good even request");
    end
    idle(1);
    a = 32'h1234_5678; c = 8'h5a;
    send(a, c, ~sender_par(a, c, 0), 0);
    check("R1", err_pulse, 1'b1, "bad even request");
    idle(1);
    clear_sticky();

    // R2: odd convention
    cur_req = "R2"; odd = 1;
    for (int i = 0; i < 30; i++) begin
      a = $urandom; c = 8'($urandom);
      send(a, c, sender_par(a, c, 1), 0);
      check("R2", err_pulse, 1'b0, "good odd request");
    end
    send(32'hffff_ffff, 8'hff, ~sender_par(32'hffff_ffff, 8'hff, 1), 1);
    check("R2", err_pulse, 1'b1, "bad odd request");
    idle(1);
    clear_sticky();

    // R3: every single-bit flip detected
    cur_req = "R3"; odd = 0;
    for (int b = 0; b < AW + CW + 1; b++) begin
      a = $urandom; c = 8'($urandom);
      par = sender_par(a, c, 0);
      if (b < AW) a[b] = ~a[b];
      else if (b < AW + CW) c[b - AW] = ~c[b - AW];
      else par = ~par;
      send(a, c, par ^ (b < AW + CW ? 1'b0 : 1'b0), 0);
      check("R3", err_pulse, 1'b1, "single-bit flip");
      idle(1);
      check("R3", err_pulse, 1'b0, "pulse ends");
    end
    clear_sticky();

    // R4: bad parity without handshake never checked
    cur_req = "R4";
    valid = 1; ready = 0; addr = 32'h0; ctrl = 8'h01; par = 0;
    for (int i = 0; i < 4; i++) begin
      tick(); check("R4", err_pulse, 1'b0, "valid without ready");
    end
    valid = 0; ready = 1;
    for (int i = 0; i < 4; i++) begin
      tick(); check("R4", err_pulse, 1'b0, "ready without valid");
    end
    check("R4", err_sticky, 1'b0, "sticky untouched");
    idle(1);

    // R5: back-to-back failures, then a pass
    cur_req = "R5";
    send(32'h1, 8'h0, 1'b0, 0);
    check("R5", err_pulse, 1'b1, "first failing");
    send(32'h3, 8'h0, 1'b1, 0);
    check("R5", err_pulse, 1'b1, "second failing");
    send(32'h3, 8'h0, 1'b0, 0);
    check("R5", err_pulse, 1'b0, "passing after failures");
    idle(1);

    // R6: sticky hold, clear, and clear colliding with a failure
    cur_req = "R6";
    idle(3);
    check("R6", err_sticky, 1'b1, "sticky holds");
    clear_sticky();
    check("R6", err_sticky, 1'b0, "clear drops sticky");
    clr = 1;
    send(32'h7, 8'h0, 1'b0, 0);
    clr = 0;
    check("R6", err_sticky, 1'b1, "failure wins over clear");
    idle(1);
    clear_sticky();

    // R7: polarity changes while stalled do not affect the waiting request
    cur_req = "R7";
    odd = 0;
    a = 32'hdead_beef; c = 8'h3c;
    valid = 1; ready = 0; addr = a; ctrl = c; par = sender_par(a, c, 0);
    tick();
    odd = 1; tick(); odd = 0; tick(); odd = 1;
    ready = 1; tick();
    check("R7", err_pulse, 1'b0, "even captured, odd set at accept");
    valid = 0; ready = 0; tick();
    a = 32'h0bad_cafe; c = 8'h81;
    valid = 1; addr = a; ctrl = c; par = sender_par(a, c, 1);
    tick(); odd = 0; tick(); ready = 1; tick();
    check("R7", err_pulse, 1'b0, "odd captured, even set at accept");
    send(a, c, sender_par(a, c, 1), 0);
    check("R7", err_pulse, 1'b1, "new request uses new select");
    idle(1);
    clear_sticky();

    // R8: fault injection by opposite polarity
    cur_req = "R8"; odd = 1;
    for (int i = 0; i < 20; i++) begin
      a = $urandom; c = 8'($urandom);
      send(a, c, sender_par(a, c, 0), i % 2);
      check("R8", err_pulse, 1'b1, "inverted polarity fails");
    end
    idle(2);
    odd = 0;

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule